// File: doc/BRIEF.md
# Software Standby Power Controller

This block steps a small processor into a clock-stopped standby state and back out again. Software selects standby with a control bit and then executes its sleep instruction. The block checks that the watchdog and bus-release settings allow the transition. It then turns off the CPU clock, the peripheral clocks and the oscillator. It holds the peripherals in reset and pulses a clear to the refresh counter. Register, RAM and port contents are left alone, because their clocks are simply stopped.

An NMI always wakes the block. An IRQ line wakes it only when its enable bit is set and the CPU is not masking interrupts. When a wake is accepted, the oscillator restarts and a settling countdown runs. The countdown length comes from a 3-bit select field. When it ends, the clocks return and a one-cycle exception request goes to the CPU, together with the latched wake source. The system reset input skips the settling countdown and supplies clocks at once. A low level on the hardware-standby pin overrides everything else.

Top module: `stby_power_ctrl`

## Requirements
- R1: In RUN, a sleep strobe with stby_sel=1 and no blocking condition moves state_o to STANDBY (1) on the next cycle. With stby_sel=0 the strobe leaves the block in RUN (0) and sets no error.
- R2: In STANDBY (1) and HW_STANDBY (3), cpu_clk_en, periph_clk_en and osc_en are 0. periph_rst is 1 in every state except RUN.
- R3: refresh_clr is a one-cycle pulse that appears in the first STANDBY cycle.
- R4: NMI always wakes STANDBY. IRQn (bit n of irq) wakes it only when irq_en[n]=1 and irq_mask=0. Any other input leaves the block in STANDBY.
- R5: A wake moves the block to SETTLE (2) for N cycles, with osc_en=1 and the clocks off. N is 8192, 16384, 32768, 65536 or 131072 for settle_sel 0 to 4, and 1024, 2048 or 4096 for settle_sel 5 to 7. settle_sel is sampled on the wake cycle.
- R6: wake_irq_req is high for exactly the first RUN cycle after SETTLE, and at no other time.
- R7: wake_src latches the source on the wake cycle and holds it until the next wake or reset. The codes are 0 none, 1 NMI, 2+n IRQn. NMI beats any IRQ, and the lower IRQ index beats a higher one.
- R8: While sys_rst_n is low the block is in RESET_HOLD (4), with clocks and osc_en on, periph_rst=1, wake_src=0 and entry_err=0. The next cycle after release is RUN, without a wake_irq_req.
- R9: A low hw_standby_n puts the block in HW_STANDBY (3) on the next cycle, from any state. Releasing it leads to RESET_HOLD and then RUN.
- R10: An entry attempt is refused when wdog_mode and wdog_run are both 1, or when bus_grant_en is 1. A refused attempt sets entry_err and the block stays in RUN.
- R11: entry_err stays set until a cycle with err_clr=1. A refused attempt in that same cycle keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator-domain clock |
| sys_rst_n | input | 1 | System reset, active low, synchronous |
| hw_standby_n | input | 1 | Hardware standby request, active low |
| sleep_strobe | input | 1 | One-cycle pulse from the sleep instruction |
| stby_sel | input | 1 | Standby-select control bit |
| settle_sel | input | 3 | Settling-time select code |
| wdog_mode | input | 1 | Watchdog in watchdog (not interval) mode |
| wdog_run | input | 1 | Watchdog timer enabled |
| bus_grant_en | input | 1 | Bus-release enable |
| err_clr | input | 1 | Clears entry_err |
| nmi | input | 1 | Non-maskable interrupt |
| irq | input | 3 | External interrupt request lines |
| irq_en | input | 3 | Per-line interrupt enables |
| irq_mask | input | 1 | CPU interrupt mask |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| periph_rst | output | 1 | Peripheral and DMA reset |
| refresh_clr | output | 1 | Clear pulse for the refresh counter and its top control bits |
| wake_irq_req | output | 1 | Interrupt exception request after wake |
| wake_src | output | 3 | Latched wake source |
| entry_err | output | 1 | Sticky refused-entry flag |
| state_o | output | 3 | Current state code |

## Verification
The bench measures the SETTLE length exactly for five select codes. A design with a wrong code-to-count table, or an off-by-one in its countdown, reports a different cycle count. It applies IRQs that are disabled, then masked. A design that ignores either qualifier leaves STANDBY. It raises NMI together with two IRQs, and two IRQs without NMI, so a wrong priority shows up as the wrong wake_src. It also drops reset in the middle of STANDBY, checks that clocks return in the very next cycle, and pulls the hardware-standby pin low during SETTLE. A design that waits for settling, or lets a pending wake win, fails those checks. A clear issued in the same cycle as a refused attempt must leave entry_err set.

// File: rtl/stby_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding and wake-source codes for the standby controller.
// Assumes: the state codes are visible to software through state_o and must not change.
package stby_pkg;
    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_STANDBY = 3'd1,
        ST_SETTLE  = 3'd2,
        ST_HWSTBY  = 3'd3,
        ST_RSTHOLD = 3'd4
    } stby_state_t;

    localparam int SRC_NONE     = 0;
    localparam int SRC_NMI      = 1;
    localparam int SRC_IRQ_BASE = 2;
endpackage

// File: rtl/stby_entry_guard.sv
`timescale 1ns/1ps
// Module: stby_entry_guard
// Decides whether a standby entry attempt may proceed, and keeps the sticky
// refused-entry flag. Assumes: attempt is already qualified by the RUN state
// and by the standby-select bit.
module stby_entry_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic attempt,
    input  logic wdog_mode,
    input  logic wdog_run,
    input  logic bus_grant_en,
    input  logic err_clr,
    output logic entry_ok,
    output logic entry_err
);
    logic blocked;

    // Refuse entry while the watchdog is armed in watchdog mode or bus release is enabled.
    always_comb begin
        blocked  = (wdog_mode && wdog_run) || bus_grant_en;
        entry_ok = attempt && !blocked;
    end

    // Sticky error: a refused attempt sets it (and wins over a clear); a clear resets it.
    always_ff @(posedge clk) begin
        if (!rst_n)                  entry_err <= 1'b0;
        else if (attempt && blocked) entry_err <= 1'b1;
        else if (err_clr)            entry_err <= 1'b0;
    end

    // R10
    refused_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (attempt && (bus_grant_en || (wdog_mode && wdog_run))) |=> entry_err);

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_err && !err_clr) |=> entry_err);
endmodule

// File: rtl/stby_wake_arbiter.sv
`timescale 1ns/1ps
// Module: stby_wake_arbiter
// Qualifies wake requests and encodes the winning source. NMI is never masked.
// IRQ lines need their enable bit and an open CPU mask.
// Assumes: inputs are already synchronous to clk.
module stby_wake_arbiter #(
    parameter int N_IRQ = 3,
    parameter int SRC_W = 3
) (
    input  logic             nmi,
    input  logic [N_IRQ-1:0] irq,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             irq_mask,
    output logic             wake,
    output logic [SRC_W-1:0] src
);
    import stby_pkg::*;

    logic [N_IRQ-1:0] elig;

    // One qualifier per IRQ line.
    for (genvar g = 0; g < N_IRQ; g++) begin : g_qual
        assign elig[g] = irq[g] && irq_en[g] && !irq_mask;
    end

    // Priority encoder: NMI first, then the lowest-numbered eligible IRQ.
    always_comb begin
        src = SRC_W'(SRC_NONE);
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (elig[i]) src = SRC_W'(SRC_IRQ_BASE + i);
        end
        if (nmi) src = SRC_W'(SRC_NMI);
        wake = nmi || (|elig);
    end
endmodule

// File: rtl/stby_settle_timer.sv
`timescale 1ns/1ps
// Module: stby_settle_timer
// Oscillator settling countdown. On load it takes the span selected by code,
// minus one, and counts down while run is high. done marks the last cycle.
// Assumes: SHORT_LOG2 + 2 < LONG_LOG2 + 5, so every span fits in CNT_W bits.
module stby_settle_timer #(
    parameter int SHORT_LOG2 = 10,
    parameter int LONG_LOG2  = 13,
    parameter int CNT_W      = LONG_LOG2 + 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [2:0] code,
    input  logic       run,
    output logic       done
);
    logic [CNT_W-1:0] cnt;

    // Codes 0..4 select the long group, codes 5..7 the short group.
    function automatic logic [CNT_W-1:0] span_m1(input logic [2:0] c);
        int sh;
        sh = (c < 3'd5) ? (LONG_LOG2 + int'(c)) : (SHORT_LOG2 + int'(c) - 5);
        return (CNT_W'(1) << sh) - CNT_W'(1);
    endfunction

    // Load on a wake, count down while settling.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (load)               cnt <= span_m1(code);
        else if (run && cnt != '0)   cnt <= cnt - CNT_W'(1);
    end

    // Done on the last settling cycle.
    always_comb done = run && (cnt == '0);

    // R5
    settle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/stby_power_ctrl.sv
`timescale 1ns/1ps
// Module: stby_power_ctrl (top)
// Sequencer for software standby: entry on sleep with standby selected, wake on a
// qualified interrupt after oscillator settling, immediate clocks on system reset,
// and a hardware-standby override. Assumes: all inputs are synchronous to clk, the
// free-running oscillator-domain clock. sys_rst_n is also the block's synchronous reset.
module stby_power_ctrl #(
    parameter int N_IRQ      = 3,
    parameter int SHORT_LOG2 = 10,
    parameter int LONG_LOG2  = 13,
    parameter int SRC_W      = $clog2(N_IRQ + 2)
) (
    input  logic             clk,
    input  logic             sys_rst_n,
    input  logic             hw_standby_n,
    input  logic             sleep_strobe,
    input  logic             stby_sel,
    input  logic [2:0]       settle_sel,
    input  logic             wdog_mode,
    input  logic             wdog_run,
    input  logic             bus_grant_en,
    input  logic             err_clr,
    input  logic             nmi,
    input  logic [N_IRQ-1:0] irq,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             irq_mask,
    output logic             cpu_clk_en,
    output logic             periph_clk_en,
    output logic             osc_en,
    output logic             periph_rst,
    output logic             refresh_clr,
    output logic             wake_irq_req,
    output logic [SRC_W-1:0] wake_src,
    output logic             entry_err,
    output logic [2:0]       state_o
);
    import stby_pkg::*;

    localparam int CNT_W = LONG_LOG2 + 5;

    stby_state_t      state_q;
    logic             attempt, entry_ok, wake, settle_done, settle_load;
    logic [SRC_W-1:0] src_now;

    // Entry attempt: sleep strobe in RUN with standby selected, pin not overriding.
    always_comb attempt = (state_q == ST_RUN) && sleep_strobe && stby_sel && hw_standby_n;
    always_comb settle_load = (state_q == ST_STANDBY) && wake && hw_standby_n;

    stby_entry_guard u_guard (
        .clk          (clk),
        .rst_n        (sys_rst_n),
        .attempt      (attempt),
        .wdog_mode    (wdog_mode),
        .wdog_run     (wdog_run),
        .bus_grant_en (bus_grant_en),
        .err_clr      (err_clr),
        .entry_ok     (entry_ok),
        .entry_err    (entry_err)
    );

    stby_wake_arbiter #(.N_IRQ(N_IRQ), .SRC_W(SRC_W)) u_arb (
        .nmi      (nmi),
        .irq      (irq),
        .irq_en   (irq_en),
        .irq_mask (irq_mask),
        .wake     (wake),
        .src      (src_now)
    );

    stby_settle_timer #(.SHORT_LOG2(SHORT_LOG2), .LONG_LOG2(LONG_LOG2), .CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (sys_rst_n),
        .load  (settle_load),
        .code  (settle_sel),
        .run   (state_q == ST_SETTLE),
        .done  (settle_done)
    );

    // State register: the pin override first, then reset, then normal sequencing.
    always_ff @(posedge clk) begin
        if (!hw_standby_n)  state_q <= ST_HWSTBY;
        else if (!sys_rst_n) state_q <= ST_RSTHOLD;
        else begin
            unique case (state_q)
                ST_RUN:     if (entry_ok)    state_q <= ST_STANDBY;
                ST_STANDBY: if (wake)        state_q <= ST_SETTLE;
                ST_SETTLE:  if (settle_done) state_q <= ST_RUN;
                ST_HWSTBY:                   state_q <= ST_RSTHOLD;
                ST_RSTHOLD:                  state_q <= ST_RUN;
                default:                     state_q <= ST_RSTHOLD;
            endcase
        end
    end

    // Registered pulses and the latched wake source.
    always_ff @(posedge clk) begin
        if (!sys_rst_n) begin
            wake_irq_req <= 1'b0;
            refresh_clr  <= 1'b0;
            wake_src     <= SRC_W'(SRC_NONE);
        end else begin
            wake_irq_req <= hw_standby_n && settle_done;
            refresh_clr  <= entry_ok;
            if (settle_load) wake_src <= src_now;
        end
    end

    // Clock, oscillator and peripheral-reset controls decoded from the state.
    always_comb begin
        cpu_clk_en    = (state_q == ST_RUN) || (state_q == ST_RSTHOLD);
        periph_clk_en = cpu_clk_en;
        osc_en        = cpu_clk_en || (state_q == ST_SETTLE);
        periph_rst    = (state_q != ST_RUN);
        state_o       = state_q;
    end

    // R1
    no_entry_without_sel_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (state_q == ST_RUN && !(sleep_strobe && stby_sel)) |=> (state_q != ST_STANDBY));

    // R4
    ineligible_stays_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (state_q == ST_STANDBY && hw_standby_n && !nmi && (((irq & irq_en) == '0) || irq_mask))
        |=> (state_q == ST_STANDBY));

    // R6
    req_after_settle_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        $rose(wake_irq_req) |-> ($past(state_q) == ST_SETTLE && state_q == ST_RUN));

    // R6
    req_single_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        wake_irq_req |=> !wake_irq_req);

    // R9
    hw_override_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !hw_standby_n |=> (state_q == ST_HWSTBY));
endmodule

// File: tb/tb_stby_power_ctrl.sv
`timescale 1ns/1ps
// Directed bench for stby_power_ctrl: one task per scenario, each checking its own results.
module tb_stby_power_ctrl;
    logic       clk = 1'b0;
    logic       sys_rst_n, hw_standby_n, sleep_strobe, stby_sel;
    logic [2:0] settle_sel;
    logic       wdog_mode, wdog_run, bus_grant_en, err_clr, nmi, irq_mask;
    logic [2:0] irq, irq_en;
    logic       cpu_clk_en, periph_clk_en, osc_en, periph_rst, refresh_clr, wake_irq_req, entry_err;
    logic [2:0] wake_src, state_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    stby_power_ctrl dut (
        .clk(clk), .sys_rst_n(sys_rst_n), .hw_standby_n(hw_standby_n),
        .sleep_strobe(sleep_strobe), .stby_sel(stby_sel), .settle_sel(settle_sel),
        .wdog_mode(wdog_mode), .wdog_run(wdog_run), .bus_grant_en(bus_grant_en),
        .err_clr(err_clr), .nmi(nmi), .irq(irq), .irq_en(irq_en), .irq_mask(irq_mask),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
        .periph_rst(periph_rst), .refresh_clr(refresh_clr), .wake_irq_req(wake_irq_req),
        .wake_src(wake_src), .entry_err(entry_err), .state_o(state_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int span(input int code);
        return (code < 5) ? (1 << (13 + code)) : (1 << (5 + code));
    endfunction

    task automatic t_reset();
        sys_rst_n = 0; hw_standby_n = 1; sleep_strobe = 0; stby_sel = 0; settle_sel = 3'd5;
        wdog_mode = 0; wdog_run = 0; bus_grant_en = 0; err_clr = 0; nmi = 0;
        irq = 0; irq_en = 0; irq_mask = 0;
        repeat (3) @(negedge clk);
        chk("R8", "state in reset", state_o, 4);
        chk("R8", "cpu clock in reset", cpu_clk_en, 1);
        chk("R8", "periph reset in reset", periph_rst, 1);
        chk("R8", "wake_src in reset", wake_src, 0);
        sys_rst_n = 1;
        @(negedge clk);
        chk("R8", "state after release", state_o, 0);
        chk("R8", "no wake req after reset", wake_irq_req, 0);
        chk("R2", "periph reset in RUN", periph_rst, 0);
    endtask

    task automatic go_standby();
        @(negedge clk);
        stby_sel = 1; sleep_strobe = 1;
        @(negedge clk);
        sleep_strobe = 0;
        chk("R1", "state after sleep", state_o, 1);
        chk("R3", "refresh clear pulse", refresh_clr, 1);
        chk("R2", "cpu clock in standby", cpu_clk_en, 0);
        chk("R2", "periph clock in standby", periph_clk_en, 0);
        chk("R2", "osc in standby", osc_en, 0);
        chk("R2", "periph reset in standby", periph_rst, 1);
        @(negedge clk);
        chk("R3", "refresh clear ends", refresh_clr, 0);
    endtask

    task automatic t_plain_sleep();
        @(negedge clk);
        stby_sel = 0; sleep_strobe = 1;
        @(negedge clk);
        sleep_strobe = 0;
        chk("R1", "sleep without select stays RUN", state_o, 0);
        chk("R1", "no error without select", entry_err, 0);
    endtask

    task automatic t_refused();
        @(negedge clk);
        wdog_mode = 1; wdog_run = 1; stby_sel = 1; sleep_strobe = 1;
        @(negedge clk);
        sleep_strobe = 0;
        chk("R10", "watchdog blocks entry", state_o, 0);
        chk("R10", "watchdog sets error", entry_err, 1);
        wdog_run = 0;
        repeat (3) @(negedge clk);
        chk("R11", "error sticky", entry_err, 1);
        err_clr = 1;
        @(negedge clk);
        err_clr = 0;
        chk("R11", "error cleared", entry_err, 0);
        bus_grant_en = 1; sleep_strobe = 1; err_clr = 1;
        @(negedge clk);
        sleep_strobe = 0; err_clr = 0; bus_grant_en = 0;
        chk("R10", "bus release blocks entry", state_o, 0);
        chk("R11", "set wins over clear", entry_err, 1);
        err_clr = 1;
        @(negedge clk);
        err_clr = 0; wdog_mode = 0;
    endtask

    task automatic t_masked();
        go_standby();
        irq = 3'b111; irq_en = 3'b000; irq_mask = 0;
        repeat (4) @(negedge clk);
        chk("R4", "disabled IRQ no wake", state_o, 1);
        irq_en = 3'b111; irq_mask = 1;
        repeat (4) @(negedge clk);
        chk("R4", "masked IRQ no wake", state_o, 1);
        chk("R2", "osc still off", osc_en, 0);
        irq = 0; irq_mask = 0;
    endtask

    task automatic t_wake(input int code, input logic nmi_v, input logic [2:0] irq_v,
                          input int exp_src, input string req);
        int n = 0;
        if (state_o != 3'd1) go_standby();
        settle_sel = 3'(code); irq_en = 3'b111; irq_mask = 0;
        @(negedge clk);
        nmi = nmi_v; irq = irq_v;
        @(posedge clk);
        while (n < 140000) begin
            @(negedge clk);
            if (cpu_clk_en) break;
            if (n == 0) begin
                chk("R5", "state settling", state_o, 2);
                chk("R5", "osc on while settling", osc_en, 1);
            end
            n++;
        end
        chk("R5", $sformatf("settle cycles code %0d", code), n, span(code));
        chk("R6", "wake request on first RUN cycle", wake_irq_req, 1);
        chk(req, "wake source", wake_src, exp_src);
        nmi = 0; irq = 0;
        @(negedge clk);
        chk("R6", "wake request one cycle", wake_irq_req, 0);
        chk("R7", "wake source held", wake_src, exp_src);
    endtask

    task automatic t_reset_in_standby();
        go_standby();
        sys_rst_n = 0;
        @(negedge clk);
        chk("R8", "reset from standby state", state_o, 4);
        chk("R8", "clocks immediately on reset", cpu_clk_en, 1);
        chk("R8", "osc immediately on reset", osc_en, 1);
        sys_rst_n = 1;
        @(negedge clk);
        chk("R8", "run after reset release", state_o, 0);
        chk("R8", "no wake req after reset exit", wake_irq_req, 0);
    endtask

    task automatic t_hw_standby();
        @(negedge clk);
        hw_standby_n = 0;
        @(negedge clk);
        chk("R9", "hw standby from RUN", state_o, 3);
        chk("R2", "clocks off in hw standby", cpu_clk_en, 0);
        chk("R2", "osc off in hw standby", osc_en, 0);
        hw_standby_n = 1;
        @(negedge clk);
        chk("R9", "reset hold after hw standby", state_o, 4);
        @(negedge clk);
        chk("R9", "run after hw standby", state_o, 0);
        go_standby();
        settle_sel = 3'd7; nmi = 1;
        repeat (5) @(negedge clk);
        nmi = 0;
        chk("R5", "settling before override", state_o, 2);
        hw_standby_n = 0;
        @(negedge clk);
        chk("R9", "hw standby from SETTLE", state_o, 3);
        hw_standby_n = 1;
        repeat (2) @(negedge clk);
        chk("R9", "run after override exit", state_o, 0);
        chk("R6", "no wake req after override", wake_irq_req, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_plain_sleep();
        t_refused();
        t_masked();
        t_wake(5, 1'b0, 3'b001, 2, "R7");
        t_wake(6, 1'b1, 3'b110, 1, "R7");
        t_wake(7, 1'b0, 3'b110, 3, "R7");
        t_wake(0, 1'b0, 3'b100, 4, "R4");
        t_wake(1, 1'b1, 3'b000, 1, "R4");
        t_reset_in_standby();
        t_hw_standby();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule